// File: doc/BRIEF.md
# Fully Associative Translation Cache With Flush

This block holds a small set of recent virtual-to-physical page mappings. Each mapping keeps its permission and dirty state. A lookup presents a full virtual address. The upper bits form the page number, and that number is compared against every stored mapping at once. On a match, the physical address, the permissions and the dirty flag come back combinationally in the same cycle. The result is built from the stored frame number and the untranslated page offset.

When no mapping matches, the block raises a miss request and shows the page number that missed. An outside walker later presents the mapping on the refill port, and the block stores it.

Software-visible events reach the block on two inputs:
- A write of the page-table base discards every mapping.
- An invalidate carrying a page number removes just that mapping.

When every slot is occupied, replacement follows least-recently-used order.

Top module: `xlat_cache`

## Requirements
- R1: After reset no slot holds a mapping, so every lookup reports a miss and no hit. While no lookup is presented, hit, permFault and missReq are all 0.
- R2: A lookup whose page number matches a stored mapping, and is not a write to a mapping with W=0, raises hit in the same cycle. paddr is then {frame number, lookup address bits [11:0]}, and permR, permW, permX and dirty show the stored bits.
- R3: A lookup with no matching mapping raises missReq in the same cycle, with missVpn equal to lookup address bits [31:12].
- R4: A refill is stored at the clock edge, so a lookup of its page number hits from the next cycle on. A refill whose page number is already stored overwrites that mapping in place, so no second copy is made.
- R5: A base write clears every mapping at the clock edge. A refill presented in the same cycle is dropped.
- R6: An invalidate removes only the mapping whose page number equals invVpn. Other mappings stay, and an invalidate with no match has no effect. A refill of the same page number in the same cycle wins, so the mapping stays.
- R7: While any slot is free, a refill of a new page number goes into a free slot and evicts no stored mapping.
- R8: When every slot is full, a refill of a new page number evicts the least recently used mapping. Use means a hit or a refill. A faulting lookup does not count as a use, and in a cycle with both a refill and a hit only the refill counts.
- R9: A write lookup (lookupWrite=1) that matches a mapping with W=0 raises permFault. In that cycle hit and missReq stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupVaddr | input | 32 | Virtual address of the lookup |
| lookupWrite | input | 1 | The lookup is for a write access |
| hit | output | 1 | Lookup translated without fault |
| permFault | output | 1 | Write lookup matched a mapping with W=0 |
| missReq | output | 1 | No mapping; request a table walk |
| missVpn | output | 20 | Page number to walk |
| paddr | output | 32 | Translated physical address |
| permR | output | 1 | Read permission of matched mapping |
| permW | output | 1 | Write permission of matched mapping |
| permX | output | 1 | Execute permission of matched mapping |
| dirty | output | 1 | Dirty flag of matched mapping |
| refillValid | input | 1 | Store a mapping this cycle |
| refillVpn | input | 20 | Page number of the mapping |
| refillPfn | input | 20 | Frame number of the mapping |
| refillR | input | 1 | Read permission to store |
| refillW | input | 1 | Write permission to store |
| refillX | input | 1 | Execute permission to store |
| refillD | input | 1 | Dirty flag to store |
| baseWrite | input | 1 | Page-table base written; discard all mappings |
| invValid | input | 1 | Invalidate one mapping this cycle |
| invVpn | input | 20 | Page number to invalidate |

## Verification
Lookup results (hit, permFault, missReq, missVpn, paddr and the permission bits) are combinational. They are due in the cycle the lookup is presented. Refill, invalidate, base-write and LRU updates take effect at the next rising edge and are first visible to the lookup in the following cycle. The bench drives inputs on the falling edge and compares lookup outputs 1 ns later, against a model holding the pre-edge state. It then advances the model at the rising edge. Eviction order is checked only through later lookups, because the slot index is not visible at the ports.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef struct packed {
    logic flushAll;
    logic invEn;
    logic refillEn;
    logic touchHit;
  } xlat_strobe_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic         lookupValid,
  input  logic         lookupWrite,
  input  logic         baseWrite,
  input  logic         invValid,
  input  logic         refillValid,
  input  logic         anyMatch,
  input  logic         matchW,
  output xlat_strobe_t strobe,
  output logic         hit,
  output logic         permFault,
  output logic         missReq
);
  always_comb begin
    permFault = lookupValid && anyMatch && lookupWrite && !matchW;
    hit       = lookupValid && anyMatch && !permFault;
    missReq   = lookupValid && !anyMatch;
    strobe.flushAll = baseWrite;
    strobe.invEn    = invValid && !baseWrite;
    strobe.refillEn = refillValid && !baseWrite;
    strobe.touchHit = hit && !baseWrite;
  end
endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  xlat_strobe_t     strobe,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [VPN_W-1:0] invVpn,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic [3:0]       refillPerm,
  output logic             anyMatch,
  output logic [PFN_W-1:0] hitPfn,
  output logic [3:0]       hitPerm
);
  // perm vector order: {R, W, X, D}
  logic             validQ [ENTRIES];
  logic [VPN_W-1:0] vpnQ   [ENTRIES];
  logic [PFN_W-1:0] pfnQ   [ENTRIES];
  logic [3:0]       permQ  [ENTRIES];
  logic [IDX_W-1:0] ageQ   [ENTRIES];

  logic [ENTRIES-1:0] lookMatch, invMatch, refMatch;

  for (genvar g = 0; g < ENTRIES; g++) begin : gCompare
    assign lookMatch[g] = validQ[g] && (vpnQ[g] == lookupVpn);
    assign invMatch[g]  = validQ[g] && (vpnQ[g] == invVpn);
    assign refMatch[g]  = validQ[g] && (vpnQ[g] == refillVpn);
  end

  logic [IDX_W-1:0] hitIdx, refIdx, freeIdx, oldIdx, targetIdx, touchIdx;
  logic             refFound, freeFound;

  always_comb begin
    hitIdx = '0; refIdx = '0; freeIdx = '0; oldIdx = '0;
    refFound = 1'b0; freeFound = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lookMatch[i]) hitIdx = IDX_W'(i);
      if (refMatch[i]) begin refIdx = IDX_W'(i); refFound = 1'b1; end
      if (!validQ[i]) begin freeIdx = IDX_W'(i); freeFound = 1'b1; end
      if (ageQ[i] == IDX_W'(ENTRIES - 1)) oldIdx = IDX_W'(i);
    end
    targetIdx = refFound ? refIdx : (freeFound ? freeIdx : oldIdx);
    touchIdx  = strobe.refillEn ? targetIdx : hitIdx;
  end

  assign anyMatch = |lookMatch;
  assign hitPfn   = pfnQ[hitIdx];
  assign hitPerm  = permQ[hitIdx];

  logic touchEn;
  assign touchEn = strobe.refillEn || strobe.touchHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        validQ[i] <= 1'b0;
        vpnQ[i]   <= '0;
        pfnQ[i]   <= '0;
        permQ[i]  <= '0;
        ageQ[i]   <= IDX_W'(i);
      end
    end else begin
      if (strobe.flushAll) begin
        for (int i = 0; i < ENTRIES; i++) validQ[i] <= 1'b0;
      end else begin
        if (strobe.invEn) begin
          for (int i = 0; i < ENTRIES; i++)
            if (invMatch[i]) validQ[i] <= 1'b0;
        end
        if (strobe.refillEn) begin
          validQ[targetIdx] <= 1'b1;
          vpnQ[targetIdx]   <= refillVpn;
          pfnQ[targetIdx]   <= refillPfn;
          permQ[targetIdx]  <= refillPerm;
        end
      end
      if (touchEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IDX_W'(i) == touchIdx) ageQ[i] <= '0;
          else if (ageQ[i] < ageQ[touchIdx]) ageQ[i] <= ageQ[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVaddr,
  input  logic             lookupWrite,
  output logic             hit,
  output logic             permFault,
  output logic             missReq,
  output logic [VPN_W-1:0] missVpn,
  output logic [PA_W-1:0]  paddr,
  output logic             permR,
  output logic             permW,
  output logic             permX,
  output logic             dirty,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic             refillR,
  input  logic             refillW,
  input  logic             refillX,
  input  logic             refillD,
  input  logic             baseWrite,
  input  logic             invValid,
  input  logic [VPN_W-1:0] invVpn
);
  xlat_strobe_t     strobe;
  logic             anyMatch;
  logic [PFN_W-1:0] hitPfn;
  logic [3:0]       hitPerm;
  logic [VPN_W-1:0] lookupVpn;

  assign lookupVpn = lookupVaddr[VA_W-1:OFF_W];

  xlat_ctrl uCtrl (
    .lookupValid(lookupValid), .lookupWrite(lookupWrite), .baseWrite(baseWrite),
    .invValid(invValid), .refillValid(refillValid), .anyMatch(anyMatch),
    .matchW(hitPerm[2]), .strobe(strobe), .hit(hit), .permFault(permFault),
    .missReq(missReq)
  );

  xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lookupVpn(lookupVpn),
    .invVpn(invVpn), .refillVpn(refillVpn), .refillPfn(refillPfn),
    .refillPerm({refillR, refillW, refillX, refillD}),
    .anyMatch(anyMatch), .hitPfn(hitPfn), .hitPerm(hitPerm)
  );

  logic showPerm;
  assign showPerm = hit || permFault;
  assign missVpn  = lookupVpn;
  assign paddr    = {hitPfn, lookupVaddr[OFF_W-1:0]};
  assign permR    = showPerm && hitPerm[3];
  assign permW    = showPerm && hitPerm[2];
  assign permX    = showPerm && hitPerm[1];
  assign dirty    = showPerm && hitPerm[0];
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   lookupValid,
  input logic [VPN_W+OFF_W-1:0] lookupVaddr,
  input logic                   lookupWrite,
  input logic                   hit,
  input logic                   permFault,
  input logic                   missReq,
  input logic [PFN_W+OFF_W-1:0] paddr,
  input logic                   refillValid,
  input logic [VPN_W-1:0]       refillVpn,
  input logic                   baseWrite,
  input logic                   invValid,
  input logic [VPN_W-1:0]       invVpn
);
  logic [VPN_W-1:0] lvpn;
  assign lvpn = lookupVaddr[VPN_W+OFF_W-1:OFF_W];

  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, permFault, missReq}));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(hit || permFault || missReq));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> paddr[OFF_W-1:0] == lookupVaddr[OFF_W-1:0]);

  assert_fault_on_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    permFault |-> lookupWrite);

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    baseWrite |=> !(hit || permFault));

  assert_refill_visible_R4: assert property (@(posedge clk) disable iff (!rstN)
    (refillValid && !baseWrite) |=>
      (!(lookupValid && lvpn == $past(refillVpn)) || hit || permFault));

  assert_inval_gone_R6: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !baseWrite && !(refillValid && refillVpn == invVpn)) |=>
      (!(lookupValid && lvpn == $past(invVpn)) || missReq));
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) uChk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
  .lookupWrite(lookupWrite), .hit(hit), .permFault(permFault), .missReq(missReq),
  .paddr(paddr), .refillValid(refillValid), .refillVpn(refillVpn),
  .baseWrite(baseWrite), .invValid(invValid), .invVpn(invVpn)
);

// File: tb/tb_xlat_cache.sv
module tb_xlat_cache;
  localparam int N = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic lookupValid = 0, lookupWrite = 0, refillValid = 0, baseWrite = 0, invValid = 0;
  logic [31:0] lookupVaddr = '0;
  logic [19:0] refillVpn = '0, refillPfn = '0, invVpn = '0, missVpn;
  logic refillR = 0, refillW = 0, refillX = 0, refillD = 0;
  logic hit, permFault, missReq, permR, permW, permX, dirty;
  logic [31:0] paddr;

  always #4 clk = ~clk;

  xlat_cache dut (.*);

  // reference model
  logic        mValid [N];
  logic [19:0] mVpn   [N];
  logic [19:0] mPfn   [N];
  logic [3:0]  mPerm  [N];
  int          mStamp [N];
  int          now = 1;
  int          nChecks = 0, nFail = 0;
  bit          done = 0;

  function automatic int mFind(logic [19:0] v);
    for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == v) return i;
    return -1;
  endfunction

  function automatic int mTarget(logic [19:0] v);
    int best;
    int f = mFind(v);
    if (f >= 0) return f;
    for (int i = 0; i < N; i++) if (!mValid[i]) return i;
    best = 0;
    for (int i = 1; i < N; i++) if (mStamp[i] < mStamp[best]) best = i;
    return best;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check 1 ns later, advance model at posedge
  task automatic step(string req, bit lv, logic [31:0] la, bit lw,
                      bit rv, logic [19:0] rvpn, logic [19:0] rpfn, logic [3:0] rperm,
                      bit bw, bit iv, logic [19:0] ivpn);
    int idx, tgt;
    bit eHit, eFault, eMiss;
    @(negedge clk);
    lookupValid = lv; lookupVaddr = la; lookupWrite = lw;
    refillValid = rv; refillVpn = rvpn; refillPfn = rpfn;
    {refillR, refillW, refillX, refillD} = rperm;
    baseWrite = bw; invValid = iv; invVpn = ivpn;
    #1;
    idx    = mFind(la[31:12]);
    eFault = lv && idx >= 0 && lw && !mPerm[idx][2];
    eHit   = lv && idx >= 0 && !eFault;
    eMiss  = lv && idx < 0;
    chk(req, {61'd0, hit, permFault, missReq}, {61'd0, eHit, eFault, eMiss});
    if (eHit) begin
      chk(req, {32'd0, paddr}, {32'd0, mPfn[idx], la[11:0]});
      chk(req, {60'd0, permR, permW, permX, dirty}, {60'd0, mPerm[idx]});
    end
    if (eMiss) chk(req, {44'd0, missVpn}, {44'd0, la[31:12]});
    @(posedge clk);
    if (bw) begin
      for (int i = 0; i < N; i++) mValid[i] = 1'b0;
    end else begin
      tgt = rv ? mTarget(rvpn) : -1;
      if (iv) for (int i = 0; i < N; i++) if (mValid[i] && mVpn[i] == ivpn) mValid[i] = 1'b0;
      if (rv) begin
        mValid[tgt] = 1'b1; mVpn[tgt] = rvpn; mPfn[tgt] = rpfn;
        mPerm[tgt] = rperm; mStamp[tgt] = now;
      end else if (eHit) mStamp[idx] = now;
    end
    now++;
  endtask

  task automatic look(string req, logic [31:0] a, bit w);
    step(req, 1, a, w, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(string req, logic [19:0] v, logic [19:0] p, logic [3:0] perm);
    step(req, 0, 0, 0, 1, v, p, perm, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mVpn[i] = 0; mPfn[i] = 0; mPerm[i] = 0; mStamp[i] = 0;
    end
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1: empty after reset, quiet when idle
    step("R1", 0, 32'h0000_5000, 0, 0, 0, 0, 0, 0, 0, 0);
    look("R1", 32'h0000_5123, 0);
    look("R3", 32'h7192_a44c, 1);

    // R4 / R2: refill then hit with offset kept
    fill("R4", 20'h7192a, 20'h14817, 4'b1100);
    look("R2", 32'h7192_a44c, 0);
    look("R2", 32'h7192_a44c, 1);
    // R9: write to a read-only mapping faults
    fill("R9", 20'h00042, 20'h00777, 4'b1010);
    look("R9", 32'h0004_2008, 1);
    look("R9", 32'h0004_2008, 0);
    // R4: overwrite in place
    fill("R4", 20'h7192a, 20'h0abcd, 4'b1111);
    look("R4", 32'h7192_afff, 1);
    // R6: invalidate miss has no effect, match removes only that entry
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1, 20'h00999);
    look("R6", 32'h0004_2000, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1, 20'h00042);
    look("R6", 32'h0004_2000, 0);
    look("R6", 32'h7192_a000, 0);
    // R6: refill and invalidate of the same page in one cycle, refill wins
    step("R6", 0, 0, 0, 1, 20'h00055, 20'h00123, 4'b1000, 0, 1, 20'h00055);
    look("R6", 32'h0005_5010, 0);
    // R5: base write with simultaneous refill
    step("R5", 0, 0, 0, 1, 20'h00066, 20'h00321, 4'b1100, 1, 0, 0);
    look("R5", 32'h0006_6000, 0);
    look("R5", 32'h7192_a000, 0);
    look("R5", 32'h0005_5000, 0);

    // R7: fill all slots, nothing evicted while free slots remain
    for (int i = 0; i < N; i++) fill("R7", 20'h00100 + 20'(i), 20'h80000 + 20'(i), 4'b1101);
    for (int i = 0; i < N; i++) look("R7", {20'h00100 + 20'(i), 12'h010}, 0);
    // R8: touch the oldest, a faulting lookup does not count, then evict
    look("R8", 32'h0010_0000, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    fill("R8", 20'h00200, 20'h90000, 4'b1000);
    look("R8", 32'h0020_0000, 1);
    fill("R8", 20'h00300, 20'h90001, 4'b1100);
    look("R8", 32'h0010_0000, 0);
    look("R8", 32'h0010_1000, 0);
    look("R8", 32'h0010_2000, 0);

    // random mix over a small page pool
    for (int k = 0; k < 4000; k++) begin
      bit lv, rv, bw, iv, lw;
      logic [19:0] lvpn, rvpn, ivpn;
      lv   = ($urandom % 100) < 80;
      rv   = ($urandom % 100) < 30;
      bw   = ($urandom % 200) == 0;
      iv   = ($urandom % 100) < 8;
      lw   = $urandom % 2;
      lvpn = 20'h00400 + 20'($urandom % 90);
      rvpn = 20'h00400 + 20'($urandom % 90);
      ivpn = 20'h00400 + 20'($urandom % 90);
      step("R8", lv, {lvpn, 12'($urandom)}, lw, rv, rvpn, 20'($urandom),
           4'($urandom), bw, iv, ivpn);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule